// File: doc/BRIEF.md
# Float/Integer Register Move Unit

This execution unit moves a value between the floating-point and the integer side of a core. It has four operations. Two are raw 64-bit copies, one in each direction. One narrows a double to single precision, under a rounding mode given with the operation, and returns the 32-bit single pattern for an integer register. One reads the low 32 bits of an integer value as a single and widens it to the equivalent double for a floating-point register. The two raw copies never touch status. The two converting forms report the class and sign of their result and raise the usual conversion exceptions.

When the record bit is set, the unit also produces a 4-bit condition field. An integer destination gets a signed comparison of the result against zero. A floating-point destination gets a snapshot of the updated floating-point summary bits. Operations enter on a valid/ready stream, and each result leaves on a valid/ready stream one cycle later.

Back-pressure rules are as follows. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. A result held with `out_ready` low keeps every output stable. A new operation can be accepted in the same cycle that the previous result is taken, so sustained throughput is one operation per cycle.

Top module: `fpmv_unit`

## Requirements
- R1: Operation code 0 (float-to-int copy) returns the 64 input bits unchanged, reports no exception bits and does not write the class field.
- R2: Operation code 2 (int-to-float copy) returns the 64 input bits unchanged, reports no exceptions, does not write the class field, and its CR1 equals the incoming flags.
- R3: Operation code 1 rounds the input double to single precision and returns the 32-bit single pattern in bits 31:0 with bits 63:32 zero.
- R4: Rounding mode codes are 0 nearest-even, 1 toward zero, 2 toward +infinity and 3 toward -infinity. Exception vector `out_exc` is {5:OX, 4:UX, 3:XX, 2:VXSNAN, 1:FR, 0:FI}. An inexact narrowing sets XX and FI, and it sets FR only when the magnitude was rounded up.
- R5: A narrowing whose rounded exponent exceeds the single range sets OX, XX and FI. The result is infinity under nearest-even, and under a directed mode that points away from zero. Otherwise the result is the largest finite single (0x7F7FFFFF with the sign applied), and FR is set only when the result is infinity.
- R6: A narrowing whose exact value is below the smallest normal single gives a subnormal or zero result. UX is set only when that result is also inexact.
- R7: Narrowing a signalling NaN gives a quiet single NaN (0x7FC00000 plus the top 22 payload bits, sign kept) and sets VXSNAN. A quiet NaN input raises nothing.
- R8: Operation code 3 widens bits 31:0 as a single to the exact double and ignores bits 63:32. Subnormal singles become normalized doubles. This form is always exact.
- R9: Widening a signalling NaN sets the quiet bit, keeps the sign and the 22-bit payload, and sets VXSNAN.
- R10: For converting forms the class code is written. The codes are +0 00010, -0 10010, +subnormal 10100, -subnormal 11000, +normal 00100, -normal 01000, +inf 00101, -inf 01001 and quiet NaN 10001.
- R11: When the invalid trap enable (`in_trap_en[3]`) is set and VXSNAN is raised, the class field is not written.
- R12: With the record bit set and an integer destination (codes 0 and 1), `out_cr` is {LT, GT, EQ, SO}. It comes from a signed 64-bit compare of the result with zero, and SO is a copy of `in_so`.
- R13: With the record bit set and a float destination (codes 2 and 3), `out_cr` is {FX, FEX, VX, OX}. FX = FX_in or any of OX/UX/XX/VXSNAN raised. VX = VX_in or VXSNAN. OX = OX_in or OX. FEX = FEX_in or any raised exception whose enable is set, with enables {3:VE, 2:OE, 1:UE, 0:XE}.
- R14: `in_ready` equals not `out_valid` or `out_ready`. A result held under back-pressure keeps all outputs stable, and results leave in acceptance order, one cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| in_op | input | 2 | Operation code (0..3, see R1-R8) |
| in_rec | input | 1 | Record bit: produce a condition field |
| in_rmode | input | 2 | Rounding mode for narrowing |
| in_data | input | 64 | Source register value |
| in_so | input | 1 | Integer summary-overflow bit |
| in_fpflags | input | 4 | Current {FX, FEX, VX, OX} |
| in_trap_en | input | 4 | Trap enables {VE, OE, UE, XE} |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 64 | Destination register value |
| out_int_dst | output | 1 | Destination is an integer register |
| out_exc | output | 6 | Raised exceptions {OX, UX, XX, VXSNAN, FR, FI} |
| out_class_we | output | 1 | Class field is to be written |
| out_class | output | 5 | Result class code |
| out_cr_we | output | 1 | Condition field is to be written |
| out_cr | output | 4 | CR0 or CR1 value |

## Verification
Two things can fall in the same clock edge: the drain of a held result and the acceptance of the next operation. They are provoked in two ways. First, every operation is offered back to back with the consumer always ready. Second, the same operations are replayed while `out_ready` follows a pseudo-random pattern. Each drained result is judged against a queue of expected items, in acceptance order, so a lost, duplicated or overwritten result shows up as a mismatch. Every cycle in which the consumer stalls is also checked for stable output data.

// File: rtl/fpmv_pkg.sv
package fpmv_pkg;
  localparam int XLEN   = 64;
  localparam int D_EXP  = 11;
  localparam int D_FRAC = 52;
  localparam int S_EXP  = 8;
  localparam int S_FRAC = 23;
  localparam int D_BIAS = (1 << (D_EXP - 1)) - 1;
  localparam int S_BIAS = (1 << (S_EXP - 1)) - 1;
  localparam int BIAS_GAP = D_BIAS - S_BIAS;
  localparam int CLS_W  = 5;
  localparam int CR_W   = 4;

  typedef enum logic [1:0] {
    OP_COPY_F2I   = 2'd0,
    OP_NARROW_F2I = 2'd1,
    OP_COPY_I2F   = 2'd2,
    OP_WIDEN_I2F  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_UP   = 2'd2,
    RM_DOWN = 2'd3
  } rm_e;

  typedef struct packed {
    logic ox;
    logic ux;
    logic xx;
    logic vxsnan;
    logic fr;
    logic fi;
  } exc_t;

  localparam logic [CLS_W-1:0] CLS_PZERO = 5'b00010;
  localparam logic [CLS_W-1:0] CLS_NZERO = 5'b10010;
  localparam logic [CLS_W-1:0] CLS_PSUB  = 5'b10100;
  localparam logic [CLS_W-1:0] CLS_NSUB  = 5'b11000;
  localparam logic [CLS_W-1:0] CLS_PNORM = 5'b00100;
  localparam logic [CLS_W-1:0] CLS_NNORM = 5'b01000;
  localparam logic [CLS_W-1:0] CLS_PINF  = 5'b00101;
  localparam logic [CLS_W-1:0] CLS_NINF  = 5'b01001;
  localparam logic [CLS_W-1:0] CLS_QNAN  = 5'b10001;

  function automatic logic [4:0] top_one(input logic [S_FRAC-1:0] v);
    logic [4:0] p;
    p = '0;
    for (int i = 0; i < S_FRAC; i++) begin
      if (v[i]) p = 5'(i);
    end
    return p;
  endfunction
endpackage

// File: rtl/fpmv_narrow.sv
module fpmv_narrow
  import fpmv_pkg::*;
(
  input  logic [XLEN-1:0]         din,
  input  rm_e                     rm,
  output logic [S_EXP+S_FRAC:0]   dout,
  output exc_t                    exc
);
  localparam int MW    = D_FRAC + 1;
  localparam int KW    = S_FRAC + 1;
  localparam int TW    = 128;
  localparam int SHMAX = KW + 2;
  localparam int EW    = 14;
  localparam logic [S_EXP-1:0] EMAX_S = {S_EXP{1'b1}};

  logic              s;
  logic [D_EXP-1:0]  e;
  logic [D_FRAC-1:0] f;
  logic [MW-1:0]     m;
  logic signed [EW-1:0] es, eo;
  logic [5:0]        sh;
  logic [TW-1:0]     t;
  logic [KW-1:0]     kept;
  logic              rnd, st, inc, inexact, to_inf;
  logic [KW:0]       sum;

  assign s = din[XLEN-1];
  assign e = din[XLEN-2 -: D_EXP];
  assign f = din[D_FRAC-1:0];

  always_comb begin
    m  = {|e, f};
    es = $signed(EW'(e == '0 ? D_EXP'(1) : e)) - EW'(BIAS_GAP);
    if (es >= 1)            sh = '0;
    else if (es < -(KW))    sh = 6'(SHMAX);
    else                    sh = 6'(EW'(1) - es);
    t    = {m, {(TW-MW){1'b0}}} >> sh;
    kept = t[TW-1 -: KW];
    rnd  = t[TW-1-KW];
    st   = |t[TW-2-KW:0];
    inexact = rnd | st;
    case (rm)
      RM_NEAR: inc = rnd & (st | kept[0]);
      RM_ZERO: inc = 1'b0;
      RM_UP:   inc = ~s & inexact;
      default: inc = s & inexact;
    endcase
    sum = {1'b0, kept} + (KW+1)'(inc);
    if (sh != '0) eo = EW'(sum[KW-1]);
    else          eo = es + EW'(sum[KW]);
    to_inf = (rm == RM_NEAR) | ((rm == RM_UP) & ~s) | ((rm == RM_DOWN) & s);

    exc  = '0;
    dout = '0;
    if (&e) begin
      if (f == '0) begin
        dout = {s, EMAX_S, {S_FRAC{1'b0}}};
      end else begin
        dout       = {s, EMAX_S, 1'b1, f[D_FRAC-2 -: S_FRAC-1]};
        exc.vxsnan = ~f[D_FRAC-1];
      end
    end else if (e == '0 && f == '0) begin
      dout = {s, {(S_EXP+S_FRAC){1'b0}}};
    end else if (eo >= EW'(EMAX_S)) begin
      dout   = to_inf ? {s, EMAX_S, {S_FRAC{1'b0}}}
                      : {s, EMAX_S - S_EXP'(1), {S_FRAC{1'b1}}};
      exc.ox = 1'b1;
      exc.xx = 1'b1;
      exc.fi = 1'b1;
      exc.fr = to_inf;
    end else begin
      dout   = {s, eo[S_EXP-1:0], sum[KW] ? {S_FRAC{1'b0}} : sum[S_FRAC-1:0]};
      exc.xx = inexact;
      exc.fi = inexact;
      exc.fr = inc;
      exc.ux = (sh != '0) & inexact;
    end
  end
endmodule

// File: rtl/fpmv_widen.sv
module fpmv_widen
  import fpmv_pkg::*;
(
  input  logic [S_EXP+S_FRAC:0] din,
  output logic [XLEN-1:0]       dout,
  output exc_t                  exc
);
  localparam int PAD = D_FRAC - S_FRAC;
  localparam int SUB_BASE = D_BIAS - S_BIAS - S_FRAC + 1;

  logic              s;
  logic [S_EXP-1:0]  e;
  logic [S_FRAC-1:0] f, fn;
  logic [4:0]        p;

  assign s = din[S_EXP+S_FRAC];
  assign e = din[S_FRAC +: S_EXP];
  assign f = din[S_FRAC-1:0];

  always_comb begin
    p    = top_one(f);
    fn   = f << (5'(S_FRAC) - p);
    exc  = '0;
    if (&e) begin
      if (f == '0) begin
        dout = {s, {D_EXP{1'b1}}, {D_FRAC{1'b0}}};
      end else begin
        dout       = {s, {D_EXP{1'b1}}, 1'b1, f[S_FRAC-2:0], {PAD{1'b0}}};
        exc.vxsnan = ~f[S_FRAC-1];
      end
    end else if (e == '0) begin
      if (f == '0) dout = {s, {(XLEN-1){1'b0}}};
      else         dout = {s, D_EXP'(p) + D_EXP'(SUB_BASE), fn, {PAD{1'b0}}};
    end else begin
      dout = {s, D_EXP'(e) + D_EXP'(BIAS_GAP), f, {PAD{1'b0}}};
    end
  end
endmodule

// File: rtl/fpmv_classify.sv
module fpmv_classify
  import fpmv_pkg::*;
#(
  parameter int EW = 8,
  parameter int FW = 23
) (
  input  logic [EW+FW:0]    v,
  output logic [CLS_W-1:0]  cls
);
  logic          s;
  logic [EW-1:0] e;
  logic [FW-1:0] f;

  assign s = v[EW+FW];
  assign e = v[FW +: EW];
  assign f = v[FW-1:0];

  always_comb begin
    if (&e) begin
      if (f != '0) cls = CLS_QNAN;
      else         cls = s ? CLS_NINF : CLS_PINF;
    end else if (e == '0) begin
      if (f == '0) cls = s ? CLS_NZERO : CLS_PZERO;
      else         cls = s ? CLS_NSUB : CLS_PSUB;
    end else begin
      cls = s ? CLS_NNORM : CLS_PNORM;
    end
  end
endmodule

// File: rtl/fpmv_cond.sv
module fpmv_cond
  import fpmv_pkg::*;
(
  input  logic            int_dst,
  input  logic [XLEN-1:0] res,
  input  logic            so_in,
  input  logic [3:0]      flags_in,
  input  logic [3:0]      trap_en,
  input  exc_t            exc,
  output logic [CR_W-1:0] cr
);
  logic raised, enabled, lt, gt, eq;

  always_comb begin
    raised  = exc.ox | exc.ux | exc.xx | exc.vxsnan;
    enabled = (trap_en[3] & exc.vxsnan) | (trap_en[2] & exc.ox) |
              (trap_en[1] & exc.ux) | (trap_en[0] & exc.xx);
    lt = res[XLEN-1];
    eq = (res == '0);
    gt = ~lt & ~eq;
    if (int_dst) cr = {lt, gt, eq, so_in};
    else cr = {flags_in[3] | raised, flags_in[2] | enabled,
               flags_in[1] | exc.vxsnan, flags_in[0] | exc.ox};
  end
endmodule

// File: rtl/fpmv_unit.sv
module fpmv_unit
  import fpmv_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [1:0]      in_op,
  input  logic            in_rec,
  input  logic [1:0]      in_rmode,
  input  logic [XLEN-1:0] in_data,
  input  logic            in_so,
  input  logic [3:0]      in_fpflags,
  input  logic [3:0]      in_trap_en,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [XLEN-1:0] out_data,
  output logic            out_int_dst,
  output logic [5:0]      out_exc,
  output logic            out_class_we,
  output logic [CLS_W-1:0] out_class,
  output logic            out_cr_we,
  output logic [CR_W-1:0] out_cr
);
  localparam int SW = S_EXP + S_FRAC + 1;

  op_e              op;
  logic [SW-1:0]    n_res;
  exc_t             n_exc, w_exc, c_exc;
  logic [XLEN-1:0]  w_res, c_res;
  logic [CLS_W-1:0] n_cls, w_cls, c_cls;
  logic [CR_W-1:0]  c_cr;
  logic             c_int, c_cwe, take;
  logic             q_raw;

  assign op       = op_e'(in_op);
  assign in_ready = ~out_valid | out_ready;
  assign take     = in_valid & in_ready;

  fpmv_narrow u_narrow (.din(in_data), .rm(rm_e'(in_rmode)), .dout(n_res), .exc(n_exc));
  fpmv_widen  u_widen  (.din(in_data[SW-1:0]), .dout(w_res), .exc(w_exc));
  fpmv_classify #(.EW(S_EXP), .FW(S_FRAC)) u_cls_s (.v(n_res), .cls(n_cls));
  fpmv_classify #(.EW(D_EXP), .FW(D_FRAC)) u_cls_d (.v(w_res), .cls(w_cls));

  always_comb begin
    c_int = ~op[1];
    case (op)
      OP_NARROW_F2I: begin c_res = {{(XLEN-SW){1'b0}}, n_res}; c_exc = n_exc; c_cls = n_cls; end
      OP_WIDEN_I2F:  begin c_res = w_res;   c_exc = w_exc; c_cls = w_cls; end
      default:       begin c_res = in_data; c_exc = '0;    c_cls = '0;    end
    endcase
    c_cwe = op[0] & ~(in_trap_en[3] & c_exc.vxsnan);
  end

  fpmv_cond u_cond (
    .int_dst(c_int), .res(c_res), .so_in(in_so), .flags_in(in_fpflags),
    .trap_en(in_trap_en), .exc(c_exc), .cr(c_cr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_data     <= '0;
      out_int_dst  <= 1'b0;
      out_exc      <= '0;
      out_class_we <= 1'b0;
      out_class    <= '0;
      out_cr_we    <= 1'b0;
      out_cr       <= '0;
      q_raw        <= 1'b0;
    end else begin
      if (take) begin
        out_valid    <= 1'b1;
        out_data     <= c_res;
        out_int_dst  <= c_int;
        out_exc      <= c_exc;
        out_class_we <= c_cwe;
        out_class    <= c_cls;
        out_cr_we    <= in_rec;
        out_cr       <= in_rec ? c_cr : '0;
        q_raw        <= ~op[0];
      end else if (out_ready) begin
        out_valid    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fpmv_unit_chk.sv
module fpmv_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [63:0] out_data,
  input logic [5:0]  out_exc,
  input logic        out_class_we,
  input logic        out_int_dst,
  input logic        out_cr_we,
  input logic [3:0]  out_cr,
  input logic        q_raw
);
  p_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_exc));
  p_ready_r14: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
  p_raw_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && q_raw |-> out_exc == 6'd0 && !out_class_we);
  p_ovf_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_exc[5] |-> out_exc[3] && out_exc[0]);
  p_tiny_inexact_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_exc[4] |-> out_exc[3]);
  p_cr0_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_cr_we && out_int_dst |-> $countones(out_cr[3:1]) == 1);
  p_cr1_snan_r13: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_cr_we && !out_int_dst && out_exc[2] |-> out_cr[3] && out_cr[1]);
endmodule

bind fpmv_unit fpmv_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_exc(out_exc),
  .out_class_we(out_class_we), .out_int_dst(out_int_dst), .out_cr_we(out_cr_we),
  .out_cr(out_cr), .q_raw(q_raw)
);

// File: tb/fpmv_unit_tb.sv
module fpmv_unit_tb;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_rec = 0, in_so = 0, out_ready = 1;
  logic [1:0] in_op = 0, in_rmode = 0;
  logic [63:0] in_data = 0;
  logic [3:0] in_fpflags = 0, in_trap_en = 0;
  logic in_ready, out_valid, out_int_dst, out_class_we, out_cr_we;
  logic [63:0] out_data;
  logic [5:0] out_exc;
  logic [4:0] out_class;
  logic [3:0] out_cr;

  always #4 clk = ~clk;

  fpmv_unit u_dut (.*);

  typedef struct packed {
    logic [63:0] data; logic [5:0] exc; logic cwe; logic [4:0] cls;
    logic crwe; logic [3:0] cr;
  } item_t;

  item_t q[$];
  string tq[$];
  int tests = 0, fails = 0;
  logic bp_mode = 0, done = 0;
  logic [7:0] lfsr = 8'hA5;

  // Consumer ready pattern, changed 2 time units after each edge
  always begin
    @(posedge clk); #2;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready = bp_mode ? lfsr[0] : 1'b1;
  end

  // Monitor: scoreboard compare, plus R14 stability under stall
  logic held = 0;
  logic [63:0] held_data;
  always begin
    @(posedge clk); #6;
    if (held) begin
      tests++;
      if (!(out_valid && out_data == held_data)) begin
        fails++;
        $display("FAIL R14 stall hold: valid=%0b data=%h expected %h", out_valid, out_data, held_data);
      end
    end
    held = out_valid && !out_ready;
    held_data = out_data;
    if (out_valid && out_ready) begin
      item_t a, x;
      string tg;
      tests++;
      if (q.size() == 0) begin
        fails++;
        $display("FAIL R14 unexpected result %h expected none", out_data);
      end else begin
        x = q.pop_front(); tg = tq.pop_front();
        a = '{out_data, out_exc, out_class_we, out_class, out_cr_we, out_cr};
        if (!x.cwe) a.cls = '0;
        if (!x.crwe) a.cr = '0;
        if (a != x) begin
          fails++;
          $display("FAIL %s: data=%h exc=%b cwe=%b cls=%b crwe=%b cr=%b expected data=%h exc=%b cwe=%b cls=%b crwe=%b cr=%b",
            tg, a.data, a.exc, a.cwe, a.cls, a.crwe, a.cr, x.data, x.exc, x.cwe, x.cls, x.crwe, x.cr);
        end
      end
    end
  end

  task automatic send(input logic [1:0] op, input logic rec, input logic [1:0] rm,
                      input logic [63:0] d, input logic so, input logic [3:0] fl,
                      input logic [3:0] en, input logic [63:0] ed, input logic [5:0] ee,
                      input logic ecwe, input logic [4:0] ecls, input logic [3:0] ecr,
                      input string tg);
    item_t x;
    @(posedge clk); #1;
    in_valid = 1; in_op = op; in_rec = rec; in_rmode = rm; in_data = d;
    in_so = so; in_fpflags = fl; in_trap_en = en;
    #4;
    while (!in_ready) begin @(posedge clk); #5; end
    x = '{ed, ee, ecwe, ecls, rec, rec ? ecr : 4'd0};
    q.push_back(x); tq.push_back(tg);
  endtask

  task automatic run_all();
    // R1 / R12: raw copy float-to-int, CR0
    send(0, 1, 0, 64'h400921FB54442D18, 0, 0, 0, 64'h400921FB54442D18, 0, 0, 0, 4'b0100, "R1 copy f2i GT");
    send(0, 1, 0, 64'h8000000000000000, 1, 0, 0, 64'h8000000000000000, 0, 0, 0, 4'b1001, "R12 LT+SO");
    send(0, 1, 0, 64'h0, 0, 0, 0, 64'h0, 0, 0, 0, 4'b0010, "R12 EQ");
    // R2 / R13: raw copy int-to-float, CR1 = incoming flags
    send(2, 1, 0, 64'h123, 0, 4'b0101, 4'b1111, 64'h123, 0, 0, 0, 4'b0101, "R2 copy i2f");
    // R3 / R10 narrowing
    send(1, 1, 0, 64'h3FF0000000000000, 0, 0, 0, 64'h3F800000, 0, 1, 5'b00100, 4'b0100, "R3 narrow 1.0");
    // R4 rounding modes on an exact halfway case
    send(1, 0, 0, 64'h3FF0000010000000, 0, 0, 0, 64'h3F800000, 6'h09, 1, 5'b00100, 0, "R4 near-even tie");
    send(1, 0, 2, 64'h3FF0000010000000, 0, 0, 0, 64'h3F800001, 6'h0B, 1, 5'b00100, 0, "R4 toward +inf");
    send(1, 0, 1, 64'h3FF0000010000000, 0, 0, 0, 64'h3F800000, 6'h09, 1, 5'b00100, 0, "R4 toward zero");
    send(1, 0, 3, 64'hBFF0000010000000, 0, 0, 0, 64'hBF800001, 6'h0B, 1, 5'b01000, 0, "R4 toward -inf neg");
    // R5 overflow
    send(1, 0, 0, 64'h7FE0000000000000, 0, 0, 0, 64'h7F800000, 6'h2B, 1, 5'b00101, 0, "R5 ovf near");
    send(1, 0, 1, 64'h7FE0000000000000, 0, 0, 0, 64'h7F7FFFFF, 6'h29, 1, 5'b00100, 0, "R5 ovf zero");
    send(1, 0, 2, 64'hFFE0000000000000, 0, 0, 0, 64'hFF7FFFFF, 6'h29, 1, 5'b01000, 0, "R5 ovf up neg");
    send(1, 0, 0, 64'h47EFFFFFF0000000, 0, 0, 0, 64'h7F800000, 6'h2B, 1, 5'b00101, 0, "R5 ovf by rounding");
    // R6 tiny results
    send(1, 0, 0, 64'h37D0000000000000, 0, 0, 0, 64'h00080000, 6'h00, 1, 5'b10100, 0, "R6 exact subnormal");
    send(1, 0, 0, 64'h3690000000000000, 0, 0, 0, 64'h00000000, 6'h19, 1, 5'b00010, 0, "R6 underflow to zero");
    send(1, 0, 2, 64'h3690000000000000, 0, 0, 0, 64'h00000001, 6'h1B, 1, 5'b10100, 0, "R6 underflow up");
    // R7 NaNs, R11 trap-enabled class suppression
    send(1, 1, 0, 64'h7FF4000000000000, 0, 0, 0, 64'h7FE00000, 6'h04, 1, 5'b10001, 4'b0100, "R7 snan narrow");
    send(1, 0, 0, 64'h7FF4000000000000, 0, 0, 4'b1000, 64'h7FE00000, 6'h04, 0, 0, 0, "R11 VE suppresses class");
    send(1, 0, 0, 64'hFFF8000000000001, 0, 0, 0, 64'hFFC00000, 6'h00, 1, 5'b10001, 0, "R7 qnan narrow");
    // R8 widening
    send(3, 1, 0, 64'hDEADBEEF3FC00000, 0, 0, 0, 64'h3FF8000000000000, 0, 1, 5'b00100, 4'b0000, "R8 widen 1.5 upper ignored");
    send(3, 0, 0, 64'h00000001, 0, 0, 0, 64'h36A0000000000000, 0, 1, 5'b00100, 0, "R8 widen min subnormal");
    send(3, 0, 0, 64'h80400000, 0, 0, 0, 64'hB800000000000000, 0, 1, 5'b01000, 0, "R8 widen neg subnormal");
    send(3, 0, 0, 64'hFF800000, 0, 0, 0, 64'hFFF0000000000000, 0, 1, 5'b01001, 0, "R10 widen -inf");
    send(3, 0, 0, 64'h80000000, 0, 0, 0, 64'h8000000000000000, 0, 1, 5'b10010, 0, "R10 widen -0");
    // R9 / R13 widening signalling NaN
    send(3, 1, 0, 64'h7FA00001, 0, 0, 0, 64'h7FFC000020000000, 6'h04, 1, 5'b10001, 4'b1010, "R9 snan widen CR1");
    send(3, 1, 0, 64'h7FA00001, 0, 0, 4'b1000, 64'h7FFC000020000000, 6'h04, 0, 0, 4'b1110, "R13 FEX with VE");
    @(posedge clk); #1 in_valid = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #5;
    tests++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      fails++;
      $display("FAIL R14 reset: valid=%b ready=%b expected valid=0 ready=1", out_valid, in_ready);
    end
    @(posedge clk); #1 rst_n = 1;
    run_all();
    while (q.size() != 0) @(posedge clk);
    bp_mode = 1;
    run_all();
    while (q.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk);
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL R14 watchdog: %0d results pending, expected 0", q.size());
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule